// File: doc/BRIEF.md
# Time-Slice Data Packetizer

This block sits between a sensor data source and a multiplexer that feeds several UDP channels. It accepts a continuous stream of data words and cuts it into chunks whose payload never exceeds a configured number of words. Each chunk is sent as one framed burst. The burst opens with header words that carry the identifier of the time slice the data belongs to and the position of the chunk within that slice. The first chunk of every slice also carries a slice-information word. The block never looks at the content of the data. Its word width is any multiple of 16 bits.

A time slice begins when the source pulses a start strobe, which carries the new slice identifier and information word. The strobe closes any chunk that is still open, so a chunk never mixes data from two slices. The strobe also restarts the chunk index. Both edges of the block use valid/ready flow control. When the consumer stalls, the producer is stalled in turn and no data is lost. The block holds back the newest accepted payload word until it can tell whether that word ends its chunk. This lets the end marker always sit on a real data word.

Top module: `slice_packetizer`

## Requirements
- R1: Each chunk is sent as contiguous output words in this order: the slice-identifier word (identifier in the low bits, zeros above), the chunk-index word (index in the low bits, zeros above), the optional information word, then the payload. `out_sop` is high only on the identifier word.
- R2: A chunk carries at most `max_words` payload words, where a setting of 0 behaves as 1. When the limit is reached, that word carries `out_eop` and the following data opens a new chunk.
- R3: The chunk index is 0 for the first chunk of each slice. It rises by one for each later chunk of the same slice and wraps modulo 2^IDX_W.
- R4: The information word appears, as the third header word, only in the first chunk of a slice. Later chunks go straight from the index word to payload.
- R5: A start strobe closes the open chunk. The last word accepted before the strobe is sent with `out_eop`, even if the chunk is shorter than the limit. Words accepted after the strobe are framed under the new slice.
- R6: `in_ready` is low in the cycle of a start strobe and in the cycle after it.
- R7: Payload words leave in the same order they were accepted, with none lost or repeated. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.
- R8: Data accepted after reset and before any strobe belongs to slice 0, with information word 0, and is framed as a first chunk. A slice that receives no data produces no output.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input data word present |
| in_ready | output | 1 | Block takes the input word this cycle |
| in_data | input | DATA_W | Input data word |
| slice_start | input | 1 | One-cycle pulse: a new time slice begins |
| slice_id | input | ID_W | Identifier of the new slice, sampled with the pulse |
| slice_info | input | DATA_W | Information word of the new slice, sampled with the pulse |
| max_words | input | LEN_W | Payload word limit per chunk |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | DATA_W | Output word (header or payload) |
| out_sop | output | 1 | First word of a chunk |
| out_eop | output | 1 | Last word of a chunk |

## Verification
Two closing causes can fall in the same cycle. A chunk can reach its word limit in the very cycle that a start strobe arrives. In that case the held last word must come out with a single end marker, and no empty or extra chunk may follow. The bench provokes this by sending slices whose length is an exact multiple of the limit. It sends the next strobe straight after the last word, while the consumer is throttled, so the full chunk is still held when the strobe lands. The bench rebuilds every expected chunk length, index and header from the slice length and the limit. It then checks that the chunk after the strobe opens with index 0 and carries the information word.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  // Position inside the chunk currently being sent
  typedef enum logic [1:0] {
    PH_ID   = 2'd0,
    PH_IDX  = 2'd1,
    PH_INFO = 2'd2,
    PH_PAY  = 2'd3
  } tsp_phase_e;

endpackage

// File: rtl/tsp_rst_sync.sv
module tsp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/tsp_slice_ctx.sv
// Keeps the slice context used by headers. A new slice is staged on the
// strobe and only takes effect once no chunk is open.
module tsp_slice_ctx #(
  parameter int DATA_W = 16,
  parameter int ID_W   = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slice_start,
  input  logic [ID_W-1:0]   slice_id,
  input  logic [DATA_W-1:0] slice_info,
  input  logic              chunk_open,
  input  logic              chunk_done,
  output logic [ID_W-1:0]   cur_id,
  output logic [DATA_W-1:0] cur_info,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              cur_first,
  output logic              switch_pend
);

  logic [ID_W-1:0]   stg_id_q;
  logic [DATA_W-1:0] stg_info_q;
  logic              sw_q, sw_d;
  logic              apply;

  logic [ID_W-1:0]   id_q, id_d;
  logic [DATA_W-1:0] info_q, info_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              first_q, first_d;
  logic              ctx_en;

  always_comb begin
    apply = sw_q && !slice_start && !chunk_open;
    sw_d  = sw_q;
    if (slice_start) begin
      sw_d = 1'b1;
    end else if (apply) begin
      sw_d = 1'b0;
    end
  end

  always_comb begin
    id_d    = id_q;
    info_d  = info_q;
    idx_d   = idx_q;
    first_d = first_q;
    if (apply) begin
      id_d    = stg_id_q;
      info_d  = stg_info_q;
      idx_d   = '0;
      first_d = 1'b1;
    end else if (chunk_done) begin
      idx_d   = idx_q + 1'b1;
      first_d = 1'b0;
    end
    ctx_en = apply || chunk_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_id_q   <= '0;
      stg_info_q <= '0;
    end else if (slice_start) begin
      stg_id_q   <= slice_id;
      stg_info_q <= slice_info;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= 1'b0;
    end else begin
      sw_q <= sw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q    <= '0;
      info_q  <= '0;
      idx_q   <= '0;
      first_q <= 1'b1;
    end else if (ctx_en) begin
      id_q    <= id_d;
      info_q  <= info_d;
      idx_q   <= idx_d;
      first_q <= first_d;
    end
  end

  assign cur_id      = id_q;
  assign cur_info    = info_q;
  assign cur_idx     = idx_q;
  assign cur_first   = first_q;
  assign switch_pend = sw_q;

endmodule

// File: rtl/tsp_hold.sv
// One-word hold stage: keeps the newest payload word and knows whether it
// already fills the chunk.
module tsp_hold #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              pay_fire,
  input  logic [LEN_W-1:0]  max_words,
  output logic              pend_v,
  output logic [DATA_W-1:0] pend_data,
  output logic              pend_last
);

  logic              v_q, v_d;
  logic [DATA_W-1:0] d_q;
  logic              last_q, last_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    v_d    = v_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    if (load) begin
      v_d    = 1'b1;
      cnt_d  = v_q ? (cnt_q + 1'b1) : LEN_W'(1);
      last_d = (cnt_d >= max_words);
    end else if (pay_fire) begin
      v_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q    <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      d_q    <= load_data;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign pend_v    = v_q;
  assign pend_data = d_q;
  assign pend_last = last_q;

endmodule

// File: rtl/tsp_frame_fsm.sv
// Sequences header and payload words and decides when a chunk closes.
module tsp_frame_fsm
  import tsp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ID_W   = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              slice_start,
  input  logic              switch_pend,
  input  logic              pend_v,
  input  logic [DATA_W-1:0] pend_data,
  input  logic              pend_last,
  input  logic [ID_W-1:0]   cur_id,
  input  logic [DATA_W-1:0] cur_info,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic              cur_first,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              in_ready,
  output logic              load,
  output logic              pay_fire,
  output logic              chunk_done
);

  tsp_phase_e        ph_q, ph_d;
  logic              ph_en;
  logic              close;
  logic              fire;
  logic [DATA_W-1:0] id_word;
  logic [DATA_W-1:0] idx_word;

  always_comb begin
    id_word                 = '0;
    id_word[ID_W-1:0]       = cur_id;
    idx_word                = '0;
    idx_word[IDX_W-1:0]     = cur_idx;
  end

  always_comb begin
    close     = pend_last || switch_pend || slice_start;
    out_valid = 1'b0;
    out_data  = pend_data;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    case (ph_q)
      PH_ID: begin
        out_valid = pend_v;
        out_data  = id_word;
        out_sop   = pend_v;
      end
      PH_IDX: begin
        out_valid = pend_v;
        out_data  = idx_word;
      end
      PH_INFO: begin
        out_valid = pend_v;
        out_data  = cur_info;
      end
      default: begin
        out_valid = pend_v && (close || in_valid);
        out_data  = pend_data;
        out_eop   = pend_v && close;
      end
    endcase

    fire       = out_valid && out_ready;
    in_ready   = (!pend_v && !switch_pend && !slice_start) ||
                 ((ph_q == PH_PAY) && pend_v && !close && out_ready);
    load       = in_valid && in_ready;
    pay_fire   = (ph_q == PH_PAY) && fire;
    chunk_done = pay_fire && close;
  end

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_ID:   if (fire) ph_d = PH_IDX;
      PH_IDX:  if (fire) ph_d = cur_first ? PH_INFO : PH_PAY;
      PH_INFO: if (fire) ph_d = PH_PAY;
      default: if (chunk_done) ph_d = PH_ID;
    endcase
    ph_en = (ph_d != ph_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_ID;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end

endmodule

// File: rtl/slice_packetizer.sv
module slice_packetizer #(
  parameter int DATA_W = 16,
  parameter int ID_W   = 8,
  parameter int IDX_W  = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              slice_start,
  input  logic [ID_W-1:0]   slice_id,
  input  logic [DATA_W-1:0] slice_info,
  input  logic [LEN_W-1:0]  max_words,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);

  localparam int WORD_UNITS = DATA_W / 16;
  localparam int HDR_WORDS  = 3;

  logic              rst_n_s;
  logic [ID_W-1:0]   cur_id;
  logic [DATA_W-1:0] cur_info;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_first;
  logic              switch_pend;
  logic              pend_v;
  logic [DATA_W-1:0] pend_data;
  logic              pend_last;
  logic              load;
  logic              pay_fire;
  logic              chunk_done;

  tsp_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  tsp_slice_ctx #(
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .IDX_W  (IDX_W)
  ) u_ctx (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .slice_start (slice_start),
    .slice_id    (slice_id),
    .slice_info  (slice_info),
    .chunk_open  (pend_v),
    .chunk_done  (chunk_done),
    .cur_id      (cur_id),
    .cur_info    (cur_info),
    .cur_idx     (cur_idx),
    .cur_first   (cur_first),
    .switch_pend (switch_pend)
  );

  tsp_hold #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (load),
    .load_data (in_data),
    .pay_fire  (pay_fire),
    .max_words (max_words),
    .pend_v    (pend_v),
    .pend_data (pend_data),
    .pend_last (pend_last)
  );

  tsp_frame_fsm #(
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .IDX_W  (IDX_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .in_valid    (in_valid),
    .slice_start (slice_start),
    .switch_pend (switch_pend),
    .pend_v      (pend_v),
    .pend_data   (pend_data),
    .pend_last   (pend_last),
    .cur_id      (cur_id),
    .cur_info    (cur_info),
    .cur_idx     (cur_idx),
    .cur_first   (cur_first),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .in_ready    (in_ready),
    .load        (load),
    .pay_fire    (pay_fire),
    .chunk_done  (chunk_done)
  );

endmodule

// File: rtl/tsp_checks.sv
module tsp_checks #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              slice_start,
  input logic [LEN_W-1:0]  max_words,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sop,
  input logic              out_eop
);

  logic [LEN_W+1:0] wc_q;
  int               lim;

  always_comb lim = (max_words == '0) ? 1 : int'(max_words);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q <= '0;
    end else if (out_valid && out_ready) begin
      wc_q <= out_sop ? (LEN_W+2)'(1) : (wc_q + 1'b1);
    end
  end

  assert_strobe_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slice_start |-> !in_ready);

  assert_strobe_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slice_start |=> !in_ready);

  assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (!out_valid || $stable(out_data)));

  assert_eop_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_valid);

  assert_sop_not_eop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> !out_eop);

  assert_chunk_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |-> (int'(wc_q) + 1 <= lim + 3));

endmodule

bind slice_packetizer tsp_checks #(
  .DATA_W (DATA_W),
  .LEN_W  (LEN_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .slice_start (slice_start),
  .max_words   (max_words),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_sop     (out_sop),
  .out_eop     (out_eop)
);

// File: tb/slice_packetizer_tb_top.sv
module slice_packetizer_tb_top;

  localparam int DW = 16;
  localparam int IW = 8;
  localparam int XW = 4;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          slice_start;
  logic [IW-1:0] slice_id;
  logic [DW-1:0] slice_info;
  logic [LW-1:0] max_words;
  logic          out_valid;
  logic          out_ready;
  logic [DW-1:0] out_data;
  logic          out_sop;
  logic          out_eop;

  always #5 clk = ~clk;

  slice_packetizer #(.DATA_W(DW), .ID_W(IW), .IDX_W(XW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .slice_start(slice_start), .slice_id(slice_id),
    .slice_info(slice_info), .max_words(max_words), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_id[256];
  int exp_info[256];
  int exp_n[256];
  int exp_m[256];
  int nsl = 0;
  int sent = 0;
  int seen = 0;
  int bp_mode = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // consumer throttle
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc++;
      case (bp_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = lfsr[0] | lfsr[5];
        default: out_ready = (cyc % 3 == 0);
      endcase
    end
  end

  // output monitor: rebuilds every chunk from slice length and limit
  initial begin
    int hs = 0;
    int ms = -1;
    int rem = 0;
    int chunk_no = 0;
    int clen = 0;
    int pc = 0;
    int m_eff = 1;
    logic [DW-1:0] exp_val = '0;
    bit prev_stall = 0;
    logic [DW-1:0] held = '0;
    forever begin
      @(negedge clk);
      #4;
      if (rst_n) begin
        if (prev_stall && out_valid)
          chk(out_data == held, "R7 hold under stall", int'(out_data), int'(held));
        prev_stall = out_valid && !out_ready;
        held = out_data;
        if (out_valid && out_ready) begin
          case (hs)
            0: begin
              if (rem == 0) begin
                ms++;
                while (ms < nsl && exp_n[ms] == 0) ms++;
                if (ms >= nsl) begin
                  chk(0, "R8 unexpected chunk", ms, nsl - 1);
                  ms = nsl - 1;
                end
                rem = exp_n[ms];
                chunk_no = 0;
              end
              m_eff = (exp_m[ms] < 1) ? 1 : exp_m[ms];
              clen = (rem < m_eff) ? rem : m_eff;
              pc = 0;
              chk(out_sop == 1'b1, "R1 sop on id word", int'(out_sop), 1);
              chk(int'(out_data) == exp_id[ms], (ms == 0) ? "R8 slice id" : "R1 slice id",
                  int'(out_data), exp_id[ms]);
              hs = 1;
            end
            1: begin
              chk(int'(out_data) == (chunk_no % 16), "R3 chunk index",
                  int'(out_data), chunk_no % 16);
              chk(!out_sop && !out_eop, "R1 header markers", int'(out_eop), 0);
              hs = (chunk_no == 0) ? 2 : 3;
            end
            2: begin
              chk(int'(out_data) == exp_info[ms], (ms == 0) ? "R8 info word" : "R4 info word",
                  int'(out_data), exp_info[ms]);
              hs = 3;
            end
            default: begin
              chk(out_data == exp_val, (chunk_no == 0 && pc == 0) ? "R4 no extra header"
                  : "R7 payload order", int'(out_data), int'(exp_val));
              exp_val++;
              pc++;
              rem--;
              seen++;
              chk(out_eop == (pc == clen), (clen < m_eff) ? "R5 eop at slice end"
                  : "R2 eop at limit", int'(out_eop), int'(pc == clen));
              if (out_eop || pc == clen) begin
                hs = 0;
                chunk_no++;
              end
            end
          endcase
        end
      end else begin
        prev_stall = 0;
      end
    end
  end

  task automatic send_word();
    bit acc = 0;
    if (bp_mode == 1 && lfsr[2]) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    while (!acc) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(sent);
      #4;
      acc = in_ready;
      @(posedge clk);
    end
    sent++;
  endtask

  task automatic send_slice(input int n);
    int s = nsl;
    exp_id[s]   = s & 255;
    exp_info[s] = 16'hA000 + s;
    exp_n[s]    = n;
    exp_m[s]    = int'(max_words);
    nsl++;
    @(negedge clk);
    in_valid    = 1'b0;
    slice_start = 1'b1;
    slice_id    = IW'(s);
    slice_info  = DW'(16'hA000 + s);
    #4;
    chk(in_ready == 1'b0, "R6 ready low on strobe", int'(in_ready), 0);
    @(negedge clk);
    slice_start = 1'b0;
    #4;
    chk(in_ready == 1'b0, "R6 ready low after strobe", int'(in_ready), 0);
    for (int i = 0; i < n; i++) send_word();
  endtask

  task automatic close_and_drain();
    send_slice(0);
    while (seen != sent) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; slice_start = 1'b0;
    slice_id = '0; slice_info = '0; max_words = LW'(2);
    exp_id[0] = 0; exp_info[0] = 0; exp_n[0] = 3; exp_m[0] = 2; nsl = 1;
    repeat (3) @(negedge clk);
    #4;
    chk(out_valid == 1'b0, "R9 valid low in reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #4;
    chk(out_valid == 1'b0, "R9 valid low after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 ready high after reset", int'(in_ready), 1);
    // R8: data before any strobe
    for (int i = 0; i < 3; i++) send_word();
    for (int b = 0; b < 3; b++) begin
      bp_mode = b;
      for (int m = 0; m < 5; m++) begin
        close_and_drain();
        max_words = LW'(m);
        for (int n = 0; n < 10; n++) send_slice(n);
      end
    end
    // R3: index wrap past 15
    close_and_drain();
    bp_mode = 0;
    max_words = LW'(1);
    send_slice(18);
    close_and_drain();
    chk(seen == sent, "R7 word count", seen, sent);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule